// File: doc/BRIEF.md
# Block Cipher Mode Chaining Unit

This unit turns a bare 128-bit block cipher engine into a full confidentiality-mode processor. The engine sits outside the unit and is reached through a request/response port. The unit supports electronic codebook, cipher block chaining, cipher feedback, output feedback and counter modes. For each block it forms the engine input from the data and the stored chaining value, and it picks the engine direction. When the engine answers, it combines the result with the data to form the output and to update the chaining value for the next block.

A caller presents one 128-bit block together with a mode code, a direction bit, a feedback segment-size code and, when a message begins, an initialization value with the new-message flag raised. The unit accepts the block, asks the engine for one transform and later returns the output block with a one-cycle done pulse. The chaining value persists between blocks, so a message is processed one block after another. Only the low 16 bits of the counter advance in counter mode, so the count wraps after 65536 blocks, which is 1 MiB of data.

Top module: `blkmode_chain`

## Requirements
- R1: With mode code 0 (codebook), and for the unused codes 5 to 7, the output is the engine result for the input block, and the engine direction follows `decrypt`. The chaining value is left unchanged.
- R2: With mode code 1 (block chaining) and `decrypt`=0, the engine receives the input XOR the chaining value. The output is the engine result, and that result becomes the new chaining value.
- R3: With mode code 1 and `decrypt`=1, the engine receives the input in the decrypt direction. The output is the engine result XOR the chaining value, and the input block becomes the new chaining value.
- R4: With mode code 2 (cipher feedback), the engine receives the chaining value. `seg_size` codes 0 to 4 select segments of 8, 16, 32, 64 or 128 bits, and codes 5 to 7 select 128 bits. The output segment is the top segment-size bits of the engine result XOR `din[s-1:0]`. It is placed in `dout[s-1:0]`, and the bits above it read zero. The chaining value shifts left by s bits and takes the ciphertext segment into its low bits. That segment is the output when encrypting and `din[s-1:0]` when decrypting.
- R5: With mode code 3 (output feedback), the engine receives the chaining value. The output is the engine result XOR the input, and the engine result becomes the new chaining value.
- R6: With mode code 4 (counter), the engine receives the chaining value as the counter block, and the output is the engine result XOR the input. Afterwards only bits [15:0] of the counter increment, modulo 2^16. Bits [127:16] are kept, so 16'hFFFF wraps to 16'h0000.
- R7: When `new_msg` is high with an accepted `start`, the block uses `iv` as its chaining value. Otherwise it continues from the value left by the previous block.
- R8: `done` is high for exactly one cycle, in the cycle after the cycle in which `eng_ack` is high. `dout` holds its value until the next done.
- R9: `eng_req` rises in the cycle after a `start` is accepted and stays high until `eng_ack`. Each block makes exactly one engine request. In modes 2, 3 and 4, `eng_dec` is 0 whatever `decrypt` is.
- R10: A `start` while `busy` is high is ignored. It neither changes the block in progress nor produces an extra done.
- R11: After reset, `busy`, `done` and `eng_req` are 0, and the chaining value is zero. A first chained block without `new_msg` therefore chains from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Present a block (accepted when not busy) |
| new_msg | input | 1 | With start: take the chaining value from iv |
| mode | input | 3 | 0 codebook, 1 block chaining, 2 cipher feedback, 3 output feedback, 4 counter |
| decrypt | input | 1 | 1 selects decryption |
| seg_size | input | 3 | Feedback segment code: 8 << code bits, 128 for codes 4 to 7 |
| iv | input | 128 | Initialization vector or initial counter block |
| din | input | 128 | Input data block |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse: dout is valid |
| dout | output | 128 | Output data block |
| eng_req | output | 1 | Request to the engine, held until eng_ack |
| eng_dec | output | 1 | Engine direction, 1 for decrypt |
| eng_data | output | 128 | Block sent to the engine |
| eng_ack | input | 1 | Engine response valid |
| eng_result | input | 128 | Engine output block |

## Verification
The unit raises `eng_req` one cycle after it accepts a block, and it raises `done` one cycle after the cycle in which `eng_ack` is high. The bench's engine stand-in acks on the third cycle of a request, so `done` must appear exactly five falling edges after `start` is driven. The bench counts those edges and checks the count. Inputs change on falling edges, and `eng_req`, `eng_dec`, `done` and `dout` are sampled on falling edges. Each sample therefore falls in a cycle whose rising edge has already updated every register along the path.

// File: rtl/blkmode_pkg.sv
`timescale 1ns/1ps
package blkmode_pkg;

   typedef enum logic [2:0] {
      MODE_ECB = 3'd0,
      MODE_CBC = 3'd1,
      MODE_CFB = 3'd2,
      MODE_OFB = 3'd3,
      MODE_CTR = 3'd4
   } mode_e;

   localparam int unsigned MODE_W = 3;
   localparam int unsigned SEGC_W = 3;
   localparam int unsigned MIN_SEG = 8;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } state_e;

endpackage

// File: rtl/blkmode_pre.sv
`timescale 1ns/1ps
module blkmode_pre
   import blkmode_pkg::*;
#(
   parameter int unsigned BLOCK_W = 128
) (
   input  logic [MODE_W-1:0]  mode,
   input  logic               decrypt,
   input  logic [BLOCK_W-1:0] din,
   input  logic [BLOCK_W-1:0] chain,
   output logic [BLOCK_W-1:0] eng_data,
   output logic               eng_dec
);

   always_comb begin
      eng_data = din;
      eng_dec  = decrypt;
      case (mode)
         MODE_CBC: begin
            eng_data = decrypt ? din : (din ^ chain);
         end
         MODE_CFB, MODE_OFB, MODE_CTR: begin
            eng_data = chain;
            eng_dec  = 1'b0;
         end
         default: begin
            eng_data = din;
         end
      endcase
   end

endmodule

// File: rtl/blkmode_cfb.sv
`timescale 1ns/1ps
module blkmode_cfb
   import blkmode_pkg::*;
#(
   parameter int unsigned BLOCK_W = 128
) (
   input  logic [SEGC_W-1:0]  seg_size,
   input  logic               decrypt,
   input  logic [BLOCK_W-1:0] din,
   input  logic [BLOCK_W-1:0] chain,
   input  logic [BLOCK_W-1:0] res,
   output logic [BLOCK_W-1:0] seg_out,
   output logic [BLOCK_W-1:0] chain_nxt
);

   localparam int unsigned NSEG = $clog2(BLOCK_W / MIN_SEG) + 1;

   logic [BLOCK_W-1:0] out_k [NSEG];
   logic [BLOCK_W-1:0] nxt_k [NSEG];

   for (genvar k = 0; k < NSEG; k++) begin : g_seg
      localparam int unsigned SW = MIN_SEG << k;
      logic [SW-1:0] piece;
      logic [SW-1:0] ct_piece;
      assign piece    = res[BLOCK_W-1 -: SW] ^ din[SW-1:0];
      assign ct_piece = decrypt ? din[SW-1:0] : piece;
      assign out_k[k] = BLOCK_W'(piece);
      assign nxt_k[k] = (chain << SW) | BLOCK_W'(ct_piece);
   end

   always_comb begin
      seg_out   = out_k[NSEG-1];
      chain_nxt = nxt_k[NSEG-1];
      for (int k = 0; k < NSEG; k++) begin
         if (seg_size == SEGC_W'(k)) begin
            seg_out   = out_k[k];
            chain_nxt = nxt_k[k];
         end
      end
   end

endmodule

// File: rtl/blkmode_post.sv
`timescale 1ns/1ps
module blkmode_post
   import blkmode_pkg::*;
#(
   parameter int unsigned BLOCK_W = 128,
   parameter int unsigned CTR_W   = 16
) (
   input  logic [MODE_W-1:0]  mode,
   input  logic               decrypt,
   input  logic [SEGC_W-1:0]  seg_size,
   input  logic [BLOCK_W-1:0] din,
   input  logic [BLOCK_W-1:0] chain,
   input  logic [BLOCK_W-1:0] res,
   output logic [BLOCK_W-1:0] dout_nxt,
   output logic [BLOCK_W-1:0] chain_nxt
);

   logic [BLOCK_W-1:0] cfb_out;
   logic [BLOCK_W-1:0] cfb_chain;
   logic [CTR_W-1:0]   ctr_low;

   blkmode_cfb #(.BLOCK_W(BLOCK_W)) u_cfb (
      .seg_size (seg_size),
      .decrypt  (decrypt),
      .din      (din),
      .chain    (chain),
      .res      (res),
      .seg_out  (cfb_out),
      .chain_nxt(cfb_chain)
   );

   assign ctr_low = chain[CTR_W-1:0] + CTR_W'(1);

   always_comb begin
      dout_nxt  = res;
      chain_nxt = chain;
      case (mode)
         MODE_CBC: begin
            if (decrypt) begin
               dout_nxt  = res ^ chain;
               chain_nxt = din;
            end else begin
               dout_nxt  = res;
               chain_nxt = res;
            end
         end
         MODE_CFB: begin
            dout_nxt  = cfb_out;
            chain_nxt = cfb_chain;
         end
         MODE_OFB: begin
            dout_nxt  = res ^ din;
            chain_nxt = res;
         end
         MODE_CTR: begin
            dout_nxt  = res ^ din;
            chain_nxt = {chain[BLOCK_W-1:CTR_W], ctr_low};
         end
         default: begin
            dout_nxt  = res;
            chain_nxt = chain;
         end
      endcase
   end

endmodule

// File: rtl/blkmode_chain.sv
`timescale 1ns/1ps
module blkmode_chain
   import blkmode_pkg::*;
#(
   parameter int unsigned BLOCK_W = 128,
   parameter int unsigned CTR_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               new_msg,
   input  logic [2:0]         mode,
   input  logic               decrypt,
   input  logic [2:0]         seg_size,
   input  logic [BLOCK_W-1:0] iv,
   input  logic [BLOCK_W-1:0] din,
   output logic               busy,
   output logic               done,
   output logic [BLOCK_W-1:0] dout,
   output logic               eng_req,
   output logic               eng_dec,
   output logic [BLOCK_W-1:0] eng_data,
   input  logic               eng_ack,
   input  logic [BLOCK_W-1:0] eng_result
);

   localparam int unsigned NSEG = $clog2(BLOCK_W / MIN_SEG) + 1;

   if (BLOCK_W < 128 || (BLOCK_W & (BLOCK_W - 1)) != 0) begin : g_bad_block
      $error("BLOCK_W must be a power of two of at least 128");
   end
   if (CTR_W == 0 || CTR_W >= BLOCK_W) begin : g_bad_ctr
      $error("CTR_W must lie between 1 and BLOCK_W-1");
   end
   if ((1 << SEGC_W) < NSEG) begin : g_bad_seg
      $error("segment code too narrow for BLOCK_W");
   end

   state_e             state_q;
   logic [MODE_W-1:0]  mode_q;
   logic               dec_q;
   logic [SEGC_W-1:0]  seg_q;
   logic [BLOCK_W-1:0] din_q;
   logic [BLOCK_W-1:0] chain_q;
   logic [BLOCK_W-1:0] dout_q;
   logic               done_q;
   logic [BLOCK_W-1:0] dout_nxt;
   logic [BLOCK_W-1:0] chain_nxt;
   logic               accept;
   logic               finish;

   assign accept = start && (state_q == ST_IDLE);
   assign finish = eng_ack && (state_q == ST_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         dec_q   <= 1'b0;
         seg_q   <= '0;
         din_q   <= '0;
         chain_q <= '0;
         dout_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= ST_WAIT;
            mode_q  <= mode;
            dec_q   <= decrypt;
            seg_q   <= seg_size;
            din_q   <= din;
            if (new_msg) chain_q <= iv;
         end else if (finish) begin
            state_q <= ST_IDLE;
            dout_q  <= dout_nxt;
            chain_q <= chain_nxt;
            done_q  <= 1'b1;
         end
      end
   end

   blkmode_pre #(.BLOCK_W(BLOCK_W)) u_pre (
      .mode    (mode_q),
      .decrypt (dec_q),
      .din     (din_q),
      .chain   (chain_q),
      .eng_data(eng_data),
      .eng_dec (eng_dec)
   );

   blkmode_post #(.BLOCK_W(BLOCK_W), .CTR_W(CTR_W)) u_post (
      .mode     (mode_q),
      .decrypt  (dec_q),
      .seg_size (seg_q),
      .din      (din_q),
      .chain    (chain_q),
      .res      (eng_result),
      .dout_nxt (dout_nxt),
      .chain_nxt(chain_nxt)
   );

   assign busy    = (state_q == ST_WAIT);
   assign eng_req = (state_q == ST_WAIT);
   assign done    = done_q;
   assign dout    = dout_q;

   assert_req_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> eng_req);

   assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_ack) |=> eng_req);

   assert_encrypt_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && (mode_q == MODE_CFB || mode_q == MODE_OFB || mode_q == MODE_CTR)) |-> !eng_dec);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_ack) |=> done);

   assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(dout));

   assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_ack) |=> ($stable(din_q) && $stable(mode_q) && busy));

   assert_ctr_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_ack && mode_q == MODE_CTR) |=>
         (chain_q[BLOCK_W-1:CTR_W] == $past(chain_q[BLOCK_W-1:CTR_W]) &&
          chain_q[CTR_W-1:0] == CTR_W'($past(chain_q[CTR_W-1:0]) + 1'b1)));

endmodule

// File: tb/blkmode_chain_test.sv
`timescale 1ns/1ps
module blkmode_chain_test;

   localparam logic [127:0] KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         new_msg = 1'b0;
   logic [2:0]   mode = '0;
   logic         decrypt = 1'b0;
   logic [2:0]   seg_size = '0;
   logic [127:0] iv = '0;
   logic [127:0] din = '0;
   logic         busy, done, eng_req, eng_dec;
   logic [127:0] dout, eng_data;
   logic         eng_ack = 1'b0;
   logic [127:0] eng_result = '0;
   int           eng_cnt = 0;

   int vectors = 0;
   int miscompares = 0;
   logic [127:0] m_chain = '0;
   logic         seen_req, seen_dec;
   int           last_lat;

   always #2 clk = ~clk;

   blkmode_chain uut (
      .clk(clk), .rst_n(rst_n), .start(start), .new_msg(new_msg),
      .mode(mode), .decrypt(decrypt), .seg_size(seg_size), .iv(iv), .din(din),
      .busy(busy), .done(done), .dout(dout),
      .eng_req(eng_req), .eng_dec(eng_dec), .eng_data(eng_data),
      .eng_ack(eng_ack), .eng_result(eng_result)
   );

   function automatic logic [127:0] f_enc(input logic [127:0] x);
      return {x[114:0], x[127:115]} ^ KEY;
   endfunction

   function automatic logic [127:0] f_dec(input logic [127:0] y);
      logic [127:0] z;
      z = y ^ KEY;
      return {z[12:0], z[127:13]};
   endfunction

   // engine stand-in: ack on the third cycle of a request
   always @(posedge clk) begin
      if (!rst_n) begin
         eng_ack <= 1'b0;
         eng_cnt <= 0;
      end else if (eng_req && !eng_ack) begin
         if (eng_cnt == 2) begin
            eng_ack    <= 1'b1;
            eng_result <= eng_dec ? f_dec(eng_data) : f_enc(eng_data);
            eng_cnt    <= 0;
         end else begin
            eng_cnt <= eng_cnt + 1;
         end
      end else begin
         eng_ack <= 1'b0;
         eng_cnt <= 0;
      end
   end

   task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [127:0] model(input logic [2:0] m, input logic d, input logic [2:0] s,
                                          input logic nm, input logic [127:0] x, input logic [127:0] ivv);
      logic [127:0] y, r, ct, mask;
      int sw;
      if (nm) m_chain = ivv;
      case (m)
         3'd1: begin
            if (!d) begin y = f_enc(x ^ m_chain); m_chain = y; end
            else begin y = f_dec(x) ^ m_chain; m_chain = x; end
         end
         3'd2: begin
            sw = (s < 3'd4) ? (8 << s) : 128;
            r = f_enc(m_chain);
            mask = (sw == 128) ? '1 : ((128'd1 << sw) - 128'd1);
            y = ((r >> (128 - sw)) ^ x) & mask;
            ct = d ? (x & mask) : y;
            m_chain = (sw == 128) ? ct : ((m_chain << sw) | ct);
         end
         3'd3: begin r = f_enc(m_chain); y = r ^ x; m_chain = r; end
         3'd4: begin
            r = f_enc(m_chain); y = r ^ x;
            m_chain = {m_chain[127:16], m_chain[15:0] + 16'd1};
         end
         default: y = d ? f_dec(x) : f_enc(x);
      endcase
      return y;
   endfunction

   task automatic run_block(input logic [2:0] m, input logic d, input logic [2:0] s,
                            input logic nm, input logic [127:0] x, output logic [127:0] y);
      @(negedge clk);
      mode = m; decrypt = d; seg_size = s; new_msg = nm; din = x; start = 1'b1;
      @(negedge clk);
      start = 1'b0; new_msg = 1'b0;
      seen_req = eng_req; seen_dec = eng_dec;
      last_lat = 1;
      while (!done && last_lat < 40) begin
         @(negedge clk);
         last_lat++;
      end
      y = dout;
   endtask

   task automatic blk(input string tag, input logic [2:0] m, input logic d, input logic [2:0] s,
                      input logic nm, input logic [127:0] x);
      logic [127:0] exp, got;
      exp = model(m, d, s, nm, x, iv);
      run_block(m, d, s, nm, x, got);
      check(tag, got, exp);
   endtask

   task automatic test_reset;
      check("R11 busy at reset", 128'(busy), 128'd0);
      check("R11 done at reset", 128'(done), 128'd0);
      check("R11 eng_req at reset", 128'(eng_req), 128'd0);
      // chaining from a zero value: no new_msg on the first block
      blk("R11 chain zero after reset", 3'd1, 1'b0, 3'd0, 1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
   endtask

   task automatic test_ecb;
      blk("R1 ecb encrypt", 3'd0, 1'b0, 3'd0, 1'b0, 128'hDEADBEEF_00000000_CAFEF00D_12345678);
      check("R1 ecb encrypt direction", 128'(seen_dec), 128'd0);
      blk("R1 ecb decrypt", 3'd0, 1'b1, 3'd0, 1'b0, 128'h0123456789ABCDEF_FEDCBA9876543210);
      check("R1 ecb decrypt direction", 128'(seen_dec), 128'd1);
      blk("R1 unused mode code 6", 3'd6, 1'b0, 3'd0, 1'b0, 128'h55AA);
   endtask

   task automatic test_cbc;
      logic [127:0] c0, c1, p;
      iv = 128'hA5A5_0000_FFFF_1234_5678_9ABC_DEF0_0F0F;
      blk("R2 R7 cbc encrypt first", 3'd1, 1'b0, 3'd0, 1'b1, 128'h1);
      blk("R2 cbc encrypt chained", 3'd1, 1'b0, 3'd0, 1'b0, 128'h2);
      c0 = f_enc(128'h1 ^ iv);
      c1 = f_enc(128'h2 ^ c0);
      run_block(3'd1, 1'b1, 3'd0, 1'b1, c0, p);
      check("R3 cbc decrypt first", p, 128'h1);
      run_block(3'd1, 1'b1, 3'd0, 1'b0, c1, p);
      check("R3 cbc decrypt chained", p, 128'h2);
      m_chain = c1;
   endtask

   task automatic test_cfb;
      for (int s = 0; s < 6; s++) begin
         iv = 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677 + 128'(s);
         blk($sformatf("R4 cfb enc seg code %0d first", s), 3'd2, 1'b0, 3'(s), 1'b1, 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F);
         check($sformatf("R4 R9 cfb enc engine encrypt %0d", s), 128'(seen_dec), 128'd0);
         blk($sformatf("R4 cfb enc seg code %0d chained", s), 3'd2, 1'b0, 3'(s), 1'b0, 128'h13579BDF2468ACE0FFFF0000AAAA5555);
      end
      iv = 128'h7777_6666_5555_4444_3333_2222_1111_0000;
      blk("R4 cfb dec 8-bit first", 3'd2, 1'b1, 3'd0, 1'b1, 128'h9C);
      check("R4 R9 cfb dec engine encrypt", 128'(seen_dec), 128'd0);
      blk("R4 cfb dec 8-bit chained", 3'd2, 1'b1, 3'd0, 1'b0, 128'h3E);
      blk("R4 cfb dec 64-bit", 3'd2, 1'b1, 3'd3, 1'b1, 128'h0123456789ABCDEF);
   endtask

   task automatic test_ofb;
      iv = 128'h1F2E3D4C5B6A79880011223344556677;
      blk("R5 ofb first", 3'd3, 1'b0, 3'd0, 1'b1, 128'hAAAA);
      blk("R5 ofb chained", 3'd3, 1'b0, 3'd0, 1'b0, 128'hBBBB);
      blk("R5 ofb decrypt bit ignored", 3'd3, 1'b1, 3'd0, 1'b0, 128'hCCCC);
      check("R5 R9 ofb engine encrypt", 128'(seen_dec), 128'd0);
   endtask

   task automatic test_ctr;
      iv = 128'hFEDC_BA98_7654_3210_0F0F_F0F0_1234_FFFE;
      blk("R6 ctr block 0", 3'd4, 1'b1, 3'd0, 1'b1, 128'd0);
      check("R6 R9 ctr engine encrypt", 128'(seen_dec), 128'd0);
      blk("R6 ctr block at ffff", 3'd4, 1'b0, 3'd0, 1'b0, 128'd0);
      blk("R6 ctr wrap to 0000", 3'd4, 1'b0, 3'd0, 1'b0, 128'h1234);
      check("R6 ctr upper kept", m_chain, {iv[127:16], 16'h0001});
   endtask

   task automatic test_newmsg;
      iv = 128'h00000000_11111111_22222222_33333333;
      blk("R7 ofb restart", 3'd3, 1'b0, 3'd0, 1'b1, 128'h5);
      blk("R7 ofb continue", 3'd3, 1'b0, 3'd0, 1'b0, 128'h5);
      blk("R7 ofb restart again", 3'd3, 1'b0, 3'd0, 1'b1, 128'h5);
   endtask

   task automatic test_timing;
      logic [127:0] y;
      iv = 128'h42;
      void'(model(3'd0, 1'b0, 3'd0, 1'b0, 128'h9, iv));
      run_block(3'd0, 1'b0, 3'd0, 1'b0, 128'h9, y);
      check("R9 eng_req one cycle after start", 128'(seen_req), 128'd1);
      check("R8 done latency", 128'(last_lat), 128'd5);
      @(negedge clk);
      check("R8 done single cycle", 128'(done), 128'd0);
      check("R8 dout held", dout, f_enc(128'h9));
   endtask

   task automatic test_busy;
      logic [127:0] exp;
      int dones;
      exp = model(3'd0, 1'b0, 3'd0, 1'b0, 128'h77, iv);
      @(negedge clk);
      mode = 3'd0; decrypt = 1'b0; din = 128'h77; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      mode = 3'd1; decrypt = 1'b1; din = 128'h99; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dones = 0;
      for (int i = 0; i < 20; i++) begin
         if (done) begin
            dones++;
            check("R10 busy start ignored result", dout, exp);
         end
         @(negedge clk);
      end
      check("R10 single done", 128'(dones), 128'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset_pre: begin
         check("R11 busy in reset", 128'(busy), 128'd0);
         check("R11 eng_req in reset", 128'(eng_req), 128'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_ecb();
      test_cbc();
      test_cfb();
      test_ofb();
      test_ctr();
      test_newmsg();
      test_timing();
      test_busy();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule